// File: doc/BRIEF.md
# Peripheral Context Save-Restore Sequencer

This block keeps the contents of a peripheral's private configuration window intact while the peripheral goes through a low-power state. When asked to save, it reads each 32-bit word of a 256-byte window, lowest offset first, through a simple register-bus master port. It keeps the words in an internal store. It then takes the peripheral type from the capability word it has just read. For every type except UART it drives the peripheral's reset-control word to zero, which parks the function and its DMA engine in reset.

When asked to restore, it first writes the release value to the reset-control word, so the function and the DMA engine come out of reset. It then writes every stored word back, lowest offset first. Each sequence ends with a one-cycle completion pulse. A restore request that arrives before any save has finished is refused with a one-cycle error pulse and causes no bus traffic. Power sequencing and the bus fabric sit outside the block.

Top module: `ctx_save_restore`

## Requirements
- R1: After reset, `bus_valid`, `seq_done`, `seq_err` and `busy` are all low, and no completed save is on record.
- R2: A save issues 64 reads (`bus_write`=0), one at a time, at byte offsets 0x00, 0x04, ... 0xFC in ascending order.
- R3: Each bus access holds `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` steady until `bus_ready` is high at a rising clock edge. The access completes on that edge, and a read takes `bus_rdata` at that edge.
- R4: After the last read of a save, the peripheral type is bits [7:4] of the word read at offset 0xFC (0 = I2C, 1 = UART, 2 = SPI). For any type other than 1, the block writes 0x00000000 to offset 0x04. For type 1 it issues no further access.
- R5: A restore first writes 0x00000007 to offset 0x04 (bits [1:0] release the function, bit 2 releases the DMA engine). It then writes the 64 stored words to offsets 0x00 through 0xFC in ascending order. Each word carries the value read at that offset by the most recent save.
- R6: `seq_done` is high for exactly one cycle when a save or a restore has finished. It is never high together with `seq_err`.
- R7: A `restore_req` taken while idle with no completed save on record causes no bus access. It raises `seq_err` for exactly one cycle.
- R8: `busy` is high from the cycle after a request is accepted until the completion pulse. While busy, `save_req` and `restore_req` are ignored and the running sequence is unchanged.
- R9: If `save_req` and `restore_req` are both high in the same idle cycle, the save is performed and the restore request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| save_req | input | 1 | Start a context save (sampled while idle) |
| restore_req | input | 1 | Start a context restore (sampled while idle) |
| seq_done | output | 1 | One-cycle pulse at the end of a save or restore |
| seq_err | output | 1 | One-cycle pulse when a restore is refused for lack of saved context |
| busy | output | 1 | A sequence is in progress |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Byte offset inside the private window |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Access completes on a rising edge where this is high |

## Verification
The hardest cases to reach from the ports are requests that arrive in the middle of a running sequence, and a save and a restore requested in the same cycle. Both depend on the block's internal phase, and a correct run shows no visible trace of them. The stimulus raises both request lines at a point where the bus is stalled partway through a save, and again on the same idle cycle. A scoreboard then requires the exact expected access list, so any extra or reordered access is reported. A second subtle case is the type decision, which uses the final word of the save itself. The bench therefore sweeps the I2C, UART and SPI codes and checks whether the reset-control word in the bus model was overwritten.

// File: rtl/ctx_pkg.sv
// Package: shared types for the context save-restore sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package ctx_pkg;

    // Sequencer phases, in the order a save or a restore walks them.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SAVE_RD  = 3'd1,
        ST_SAVE_RST = 3'd2,
        ST_RELEASE  = 3'd3,
        ST_REST_WR  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/ctx_store.sv
// Module: ctx_store
// Word store that holds the saved window, one entry per 32-bit word.
// Assumes: one write port and one asynchronous read port, indexed by
// the shared word counter. Contents are undefined until the first save.
module ctx_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [WORDS];

    // Capture one word per completed read during a save.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Present the word addressed by the counter for write-back.
    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/ctx_word_ctr.sv
// Module: ctx_word_ctr
// Word index counter that walks the window in ascending order.
// Assumes: clear has priority over increment; synchronous active-low reset.
module ctx_word_ctr #(
    parameter int WORDS  = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    // Step the index on each completed word access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + IDX_W'(1);
        end
    end

    // Flag the final word of the window.
    assign last = (idx == IDX_W'(WORDS - 1));

endmodule

// File: rtl/ctx_fsm.sv
// Module: ctx_fsm
// Control state machine for the save and restore sequences.
// Assumes: requests are sampled only in ST_IDLE, and save wins a tie.
// An access completes on any edge where the top presents an access and
// bus_ready is high. The UART decision comes from the type field of the
// capability word, captured while the save reads it.
module ctx_fsm
    import ctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       save_req,
    input  logic       restore_req,
    input  logic       bus_ready,
    input  logic       word_last,
    input  logic       caps_hit,
    input  logic       caps_is_uart,
    output seq_state_t state,
    output logic       skip_reset,
    output logic       ctr_clr,
    output logic       ctr_inc,
    output logic       store_we,
    output logic       done,
    output logic       err
);

    logic ctx_valid;
    logic acc_ok;

    // An access in the current phase completes on this edge.
    always_comb begin
        unique case (state)
            ST_SAVE_RD, ST_RELEASE, ST_REST_WR: acc_ok = bus_ready;
            ST_SAVE_RST:                        acc_ok = bus_ready || skip_reset;
            default:                            acc_ok = 1'b0;
        endcase
    end

    // Counter and store controls for the current phase.
    always_comb begin
        ctr_clr  = (state == ST_IDLE) || (state == ST_RELEASE);
        ctr_inc  = acc_ok && ((state == ST_SAVE_RD) || (state == ST_REST_WR));
        store_we = acc_ok && (state == ST_SAVE_RD);
    end

    // Phase sequencing, completion and error pulses, saved-context flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            skip_reset <= 1'b0;
            ctx_valid  <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (save_req) begin
                        state <= ST_SAVE_RD;
                    end else if (restore_req) begin
                        if (ctx_valid) begin
                            state <= ST_RELEASE;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_SAVE_RD: begin
                    if (acc_ok) begin
                        if (caps_hit) begin
                            skip_reset <= caps_is_uart;
                        end
                        if (word_last) begin
                            state <= ST_SAVE_RST;
                        end
                    end
                end
                ST_SAVE_RST: begin
                    if (acc_ok) begin
                        ctx_valid <= 1'b1;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                ST_RELEASE: begin
                    if (acc_ok) begin
                        state <= ST_REST_WR;
                    end
                end
                ST_REST_WR: begin
                    if (acc_ok && word_last) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ctx_save_restore.sv
// Module: ctx_save_restore (top)
// Saves a peripheral's private register window into a local store and
// writes it back later, parking and releasing the peripheral's resets
// around the low-power transition.
// Assumes: a single-outstanding register bus where an access completes
// on a rising edge with bus_ready high; the capability word lies inside
// the saved window; the window size is a power-of-two number of words.
module ctx_save_restore
    import ctx_pkg::*;
#(
    parameter int                 DATA_W       = 32,
    parameter int                 ADDR_W       = 8,
    parameter int                 WINDOW_BYTES = 256,
    parameter logic [ADDR_W-1:0]  RST_OFS      = 8'h04,
    parameter logic [ADDR_W-1:0]  CAPS_OFS     = 8'hFC,
    parameter int                 TYPE_LSB     = 4,
    parameter int                 TYPE_W       = 4,
    parameter int                 UART_CODE    = 1,
    parameter logic [DATA_W-1:0]  RELEASE_VAL  = 32'h0000_0007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_req,
    input  logic              restore_req,
    output logic              seq_done,
    output logic              seq_err,
    output logic              busy,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);

    localparam int BYTES_PER_WORD = DATA_W / 8;
    localparam int WORDS          = WINDOW_BYTES / BYTES_PER_WORD;
    localparam int IDX_W          = $clog2(WORDS);
    localparam int ALIGN_W        = $clog2(BYTES_PER_WORD);
    localparam int CAPS_IDX       = int'(CAPS_OFS) / BYTES_PER_WORD;

    seq_state_t        state;
    logic              skip_reset;
    logic              ctr_clr;
    logic              ctr_inc;
    logic              store_we;
    logic [IDX_W-1:0]  word_idx;
    logic              word_last;
    logic [DATA_W-1:0] store_rd;
    logic [ADDR_W-1:0] word_addr;
    logic              caps_hit;
    logic              caps_is_uart;

    ctx_word_ctr #(.WORDS(WORDS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .idx   (word_idx),
        .last  (word_last)
    );

    ctx_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
        .clk     (clk),
        .wr_en   (store_we),
        .wr_idx  (word_idx),
        .wr_data (bus_rdata),
        .rd_idx  (word_idx),
        .rd_data (store_rd)
    );

    ctx_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .save_req     (save_req),
        .restore_req  (restore_req),
        .bus_ready    (bus_ready),
        .word_last    (word_last),
        .caps_hit     (caps_hit),
        .caps_is_uart (caps_is_uart),
        .state        (state),
        .skip_reset   (skip_reset),
        .ctr_clr      (ctr_clr),
        .ctr_inc      (ctr_inc),
        .store_we     (store_we),
        .done         (seq_done),
        .err          (seq_err)
    );

    // Byte offset of the current word and type decode of the capability word.
    assign word_addr    = ADDR_W'({word_idx, {ALIGN_W{1'b0}}});
    assign caps_hit     = (word_idx == IDX_W'(CAPS_IDX));
    assign caps_is_uart = (bus_rdata[TYPE_LSB +: TYPE_W] == TYPE_W'(UART_CODE));
    assign busy         = (state != ST_IDLE);

    // Drive the bus master port from the current phase.
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_SAVE_RD: begin
                bus_valid = 1'b1;
                bus_addr  = word_addr;
            end
            ST_SAVE_RST: begin
                bus_valid = !skip_reset;
                bus_write = 1'b1;
                bus_addr  = RST_OFS;
            end
            ST_RELEASE: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = RST_OFS;
                bus_wdata = RELEASE_VAL;
            end
            ST_REST_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = word_addr;
                bus_wdata = store_rd;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctx_save_restore_chk.sv
// Module: ctx_save_restore_chk
// Port-level properties of the save-restore sequencer, bound to the top.
// Assumes: synchronous active-low reset; all properties are disabled in reset.
module ctx_save_restore_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seq_done,
    input logic              seq_err,
    input logic              busy,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready
);

    // R3: a stalled access keeps its request and its fields.
    p_hold_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                       && $stable(bus_write) && $stable(bus_wdata)));

    // R2: every access is word aligned.
    p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr[1:0] == 2'b00));

    // R5: a write burst starting from idle begins with the reset release.
    p_release_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_valid) && bus_write) |-> (bus_addr == ADDR_W'(4) && bus_wdata == DATA_W'(7)));

    // R6: the completion pulse lasts a single cycle.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R6: completion and error never coincide.
    p_done_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_err));

    // R7: a refused restore produces no bus access and no sequence.
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (!bus_valid && !busy));

    // R7: the error pulse lasts a single cycle.
    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> !seq_err);

    // R8: bus traffic only while a sequence is running.
    p_valid_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> busy);

endmodule

bind ctx_save_restore ctx_save_restore_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_done  (seq_done),
    .seq_err   (seq_err),
    .busy      (busy),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready)
);

// File: tb/tb_ctx_save_restore.sv
module tb_ctx_save_restore;

    localparam int NW    = 64;
    localparam int QSIZE = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        save_req = 1'b0;
    logic        restore_req = 1'b0;
    logic        seq_done, seq_err, busy;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ready;

    always #4 clk = ~clk;

    ctx_save_restore dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .seq_done    (seq_done),
        .seq_err     (seq_err),
        .busy        (busy),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_ready   (bus_ready)
    );

    // Scoreboard queue: written by the driver side, popped by the monitor.
    logic        exp_wr   [QSIZE];
    logic [7:0]  exp_addr [QSIZE];
    logic [31:0] exp_data [QSIZE];
    int          exp_req  [QSIZE];
    int          q_tail = 0;
    int          q_head = 0;

    // Bus model and its preload image.
    logic [31:0] slave_mem [NW];
    logic [31:0] load_img  [NW];
    logic [31:0] saved_img [NW];
    logic        load_now = 1'b0;
    logic        stall_mode = 1'b0;
    logic        ready_r = 1'b1;
    logic [7:0]  lfsr = 8'hA7;

    int n_checks = 0, n_fail = 0;
    int m_checks = 0, m_fail = 0;
    logic finished = 1'b0;

    assign bus_rdata = slave_mem[bus_addr[7:2]];
    assign bus_ready = ready_r;

    // Ready pattern, changed away from the active edge.
    always @(negedge clk) begin
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ready_r <= stall_mode ? lfsr[0] : 1'b1;
    end

    // Monitor: pops expected accesses and applies writes to the bus model.
    always @(posedge clk) begin
        if (load_now) begin
            for (int i = 0; i < NW; i++) slave_mem[i] <= load_img[i];
        end else if (rst_n && bus_valid && bus_ready) begin
            m_checks++;
            if (q_head == q_tail) begin
                m_fail++;
                $display("FAIL R8 unexpected access wr=%0b addr=%h data=%h, expected none",
                         bus_write, bus_addr, bus_wdata);
            end else begin
                if (bus_write !== exp_wr[q_head] || bus_addr !== exp_addr[q_head] ||
                    (exp_wr[q_head] && bus_wdata !== exp_data[q_head])) begin
                    m_fail++;
                    $display("FAIL R%0d access wr=%0b addr=%h data=%h, expected wr=%0b addr=%h data=%h",
                             exp_req[q_head], bus_write, bus_addr, bus_wdata,
                             exp_wr[q_head], exp_addr[q_head], exp_data[q_head]);
                end
                q_head = q_head + 1;
            end
            if (bus_write) slave_mem[bus_addr[7:2]] <= bus_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic wr, input logic [7:0] a, input logic [31:0] d, input int rq);
        exp_wr[q_tail] = wr; exp_addr[q_tail] = a; exp_data[q_tail] = d; exp_req[q_tail] = rq;
        q_tail++;
    endtask

    // Driver: expected save traffic from the current bus-model image (R2, R4).
    task automatic push_save();
        for (int i = 0; i < NW; i++) begin
            saved_img[i] = slave_mem[i];
            push(1'b0, 8'(i * 4), 32'h0, 2);
        end
        if (slave_mem[NW-1][7:4] != 4'd1) push(1'b1, 8'h04, 32'h0, 4);
    endtask

    // Driver: expected restore traffic (R5).
    task automatic push_restore();
        push(1'b1, 8'h04, 32'h7, 5);
        for (int i = 0; i < NW; i++) push(1'b1, 8'(i * 4), saved_img[i], 5);
    endtask

    task automatic load(input logic [31:0] seed, input logic [3:0] ptype);
        for (int i = 0; i < NW; i++) load_img[i] = seed ^ (32'(i) * 32'h0101_0103);
        load_img[NW-1] = (load_img[NW-1] & ~32'hF0) | {24'h0, ptype, 4'h0};
        @(negedge clk); load_now = 1'b1;
        @(negedge clk); load_now = 1'b0;
    endtask

    task automatic pulse(input logic s, input logic r);
        @(negedge clk); save_req = s; restore_req = r;
        @(negedge clk); save_req = 1'b0; restore_req = 1'b0;
    endtask

    // Wait for completion, then confirm the pulse width (R6).
    task automatic wait_done(input string tag);
        bit got = 1'b0;
        for (int c = 0; c < 4000 && !got; c++) begin
            if (seq_done) got = 1'b1;
            else @(negedge clk);
        end
        check(got, "R6", {tag, " done seen"}, 32'(got), 32'h1);
        @(negedge clk);
        check(seq_done == 1'b0, "R6", {tag, " done one cycle"}, 32'(seq_done), 32'h0);
        check(q_head == q_tail, "R2", {tag, " expected accesses drained"}, 32'(q_tail - q_head), 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset.
        check(!bus_valid && !seq_done && !seq_err && !busy, "R1", "reset outputs",
              {28'h0, bus_valid, seq_done, seq_err, busy}, 32'h0);

        // R7: restore with nothing saved is refused.
        load(32'h1234_5678, 4'd2);
        @(negedge clk); restore_req = 1'b1;
        @(negedge clk); restore_req = 1'b0;
        check(seq_err == 1'b1, "R7", "error pulse", 32'(seq_err), 32'h1);
        check(!busy && !seq_done, "R7", "no sequence started", {30'h0, busy, seq_done}, 32'h0);
        @(negedge clk);
        check(seq_err == 1'b0, "R7", "error one cycle", 32'(seq_err), 32'h0);
        repeat (3) @(negedge clk);
        check(q_head == q_tail && slave_mem[1] == load_img[1], "R7", "no bus access",
              slave_mem[1], load_img[1]);

        // R2 R3 R4: SPI save with a stalling bus, reset parked.
        stall_mode = 1'b1;
        push_save();
        pulse(1'b1, 1'b0);
        wait_done("spi save");
        check(slave_mem[1] == 32'h0, "R4", "spi reset word cleared", slave_mem[1], 32'h0);

        // R5: restore into a scrambled window.
        load(32'hDEAD_0000, 4'd7);
        push_restore();
        pulse(1'b0, 1'b1);
        wait_done("restore 1");
        begin
            int bad = 0;
            for (int i = 0; i < NW; i++) if (slave_mem[i] !== saved_img[i]) bad++;
            check(bad == 0, "R5", "window restored", 32'(bad), 32'h0);
        end

        // R4: UART save leaves the reset word untouched.
        stall_mode = 1'b0;
        load(32'h0BAD_CAFE, 4'd1);
        push_save();
        pulse(1'b1, 1'b0);
        wait_done("uart save");
        check(slave_mem[1] == load_img[1], "R4", "uart reset word kept", slave_mem[1], load_img[1]);

        // R8: requests during an I2C save are ignored.
        stall_mode = 1'b1;
        load(32'h5A5A_1111, 4'd0);
        push_save();
        pulse(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        check(busy == 1'b1, "R8", "busy mid save", 32'(busy), 32'h1);
        pulse(1'b1, 1'b1);
        wait_done("i2c save");
        check(slave_mem[1] == 32'h0, "R4", "i2c reset word cleared", slave_mem[1], 32'h0);

        // R9: simultaneous requests pick the save.
        load(32'h7777_0F0F, 4'd2);
        push_save();
        pulse(1'b1, 1'b1);
        wait_done("tie save");

        // R5: restore of the latest save over a fresh image.
        load(32'h0000_FFFF, 4'd3);
        push_restore();
        pulse(1'b0, 1'b1);
        wait_done("restore 2");
        check(slave_mem[NW-1] == saved_img[NW-1], "R5", "last word restored",
              slave_mem[NW-1], saved_img[NW-1]);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks + m_checks, n_fail + m_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks + m_checks + 1, n_fail + m_fail + 1);
            $finish;
        end
    end

endmodule